// File: doc/BRIEF.md
# ADC Monitor Control Byte Decoder

This block takes the bytes of a write transaction from a serial slave byte interface and sorts each one into one of two control registers. The interface layer marks each received byte with a one-cycle valid strobe and marks every start or stop condition with a boundary strobe. A byte with its top bit set updates the setup register, which holds the reference choice, the reference power control, the conversion clock source and the unipolar/bipolar request. A byte with its top bit clear updates the configuration register, which holds the input-channel code and the single-ended/differential choice.

The block then works out the settings that the converter core uses. Single-ended mode always gives a unipolar conversion. The channel code, together with the input mode, gives the positive and negative converter inputs. A setup byte can also carry two extra commands. One is an active-low reset that clears the configuration register and pulses an interrupt-clear signal. The other is a monitor flag. When it is set, the next bytes of the same transaction are shifted into a 104-bit monitor parameter bus instead of being decoded as control bytes.

All outputs come straight from registers, or from combinational logic fed only by registers. No input reaches an output in the same cycle.

Top module: `mon_ctl_decoder`

## Requirements
- R1: After reset the setup fields are all zero: `ref_sel`=00, `ref_pwr_on`=0, `clk_ext`=0, unipolar requested. The configuration is single-ended with channel 0. `int_clr`=0 and `mon_params`=0. These values match a power-up setup byte of 0x82.
- R2: An accepted byte with bit 7 = 1 loads bits 6:5 into `ref_sel`, bit 4 into `ref_pwr_on` (1 = reference kept powered), bit 3 into `clk_ext` (1 = bus clock) and bit 2 into the unipolar/bipolar request (1 = bipolar). The new values appear on the clock edge that takes the byte. Such a byte leaves the configuration register unchanged unless R4 applies.
- R3: An accepted byte with bit 7 = 0 loads bit 0 as the input mode (1 = single-ended) and bits 2:1 as the channel code. Bits 6:3 are ignored, and the setup fields stay unchanged.
- R4: A setup byte with bit 1 = 0 returns the configuration to single-ended channel 0. It also drives `int_clr` high for exactly the one cycle after the byte. Its other setup fields still load, and `mon_params` is unchanged. A setup byte with bit 1 = 1 clears nothing.
- R5: `bipolar` is 1 only when the input mode is differential and the bipolar request is 1. `single_ended` reflects the stored input mode.
- R6: In single-ended mode `pos_ch` equals the channel code and `neg_en`=0. In differential mode `neg_en`=1 and the code gives these input pairs: 00 gives positive 0 and negative 1; 01 gives positive 1 and negative 0; 10 gives positive 2 and negative 3; 11 gives positive 3 and negative 2.
- R7: `ain3_is_ref` equals `ref_sel[0]`, meaning pin 3 is the reference pin. `ref_internal` equals `ref_sel[1]`, meaning the internal reference is chosen. When both are 0, the supply is the reference.
- R8: A setup byte with bit 0 = 1 starts a monitor load. Each of up to 13 following accepted bytes is shifted into `mon_params`, most significant byte first, so the first byte ends in bits 103:96 after 13 bytes. These bytes never reach the setup or configuration register.
- R9: After the 13th monitor byte, further bytes are ignored until a boundary strobe. A boundary strobe during a load ends it and keeps the bytes already shifted. After any boundary, bytes are decoded as control bytes again.
- R10: A byte whose valid strobe arrives in the same cycle as a boundary strobe is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld | input | 1 | One-cycle strobe for a received write byte |
| byte_data | input | 8 | Received byte |
| xfer_bound | input | 1 | Start or stop condition seen |
| ref_sel | output | 2 | Stored reference select code |
| ain3_is_ref | output | 1 | Pin 3 serves as the reference pin |
| ref_internal | output | 1 | Internal reference selected |
| ref_pwr_on | output | 1 | Keep the internal reference powered |
| clk_ext | output | 1 | Convert with the bus clock |
| single_ended | output | 1 | Effective input mode is single-ended |
| bipolar | output | 1 | Effective conversion is bipolar |
| pos_ch | output | 2 | Positive input channel |
| neg_ch | output | 2 | Negative input channel (valid when neg_en) |
| neg_en | output | 1 | Negative input in use (differential) |
| int_clr | output | 1 | One-cycle interrupt-clear pulse |
| mon_params | output | 104 | Monitor parameter bus |

## Verification
The bench sends a setup byte that has the bipolar request set while single-ended mode is active. A decoder that did not force the override would then report bipolar. The bench runs every differential channel code, so a wrong pair table would swap the negative input. It sends the active-low reset with other fields set: a design that skipped those fields or wiped the setup register would show a stale or zeroed reference choice. The monitor load is driven past its 13th byte, cut short by a boundary, and hit by a byte that lands together with a boundary. A design that miscounted would corrupt `mon_params`, and one that kept decoding extra bytes would change the control registers.

// File: rtl/mcd_pkg.sv
package mcd_pkg;

  localparam int BYTE_W    = 8;
  localparam int KIND_BIT  = 7;
  localparam int CLRN_BIT  = 1;
  localparam int MON_BIT   = 0;

  typedef struct packed {
    logic [1:0] ref_sel;
    logic       pwr_on;
    logic       clk_ext;
    logic       bip_req;
  } setup_t;

  typedef struct packed {
    logic [1:0] code;
    logic       se;
  } cfg_t;

  localparam setup_t SETUP_RST = '{ref_sel: 2'b00, pwr_on: 1'b0, clk_ext: 1'b0, bip_req: 1'b0};
  localparam cfg_t   CFG_RST   = '{code: 2'b00, se: 1'b1};

  typedef enum logic [1:0] {LD_IDLE, LD_SHIFT, LD_DRAIN} ld_state_e;

  function automatic setup_t setup_from_byte(input logic [BYTE_W-1:0] b);
    setup_t s;
    s.ref_sel = b[6:5];
    s.pwr_on  = b[4];
    s.clk_ext = b[3];
    s.bip_req = b[2];
    return s;
  endfunction

  function automatic cfg_t cfg_from_byte(input logic [BYTE_W-1:0] b);
    cfg_t c;
    c.code = b[2:1];
    c.se   = b[0];
    return c;
  endfunction

  function automatic logic eff_bipolar(input cfg_t c, input setup_t s);
    return !c.se && s.bip_req;
  endfunction

  // differential pairs are neighbours: partner differs only in bit 0
  function automatic logic [1:0] partner_ch(input logic [1:0] code);
    return {code[1], ~code[0]};
  endfunction

endpackage

// File: rtl/mcd_setup_reg.sv
module mcd_setup_reg
  import mcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] din,
  output setup_t            q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= SETUP_RST;
    else if (load) q <= setup_from_byte(din);
  end
endmodule

// File: rtl/mcd_cfg_reg.sv
module mcd_cfg_reg
  import mcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              clear,
  input  logic [BYTE_W-1:0] din,
  output cfg_t              q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= CFG_RST;
    else if (clear) q <= CFG_RST;
    else if (load)  q <= cfg_from_byte(din);
  end
endmodule

// File: rtl/mcd_mon_loader.sv
module mcd_mon_loader
  import mcd_pkg::*;
#(
  parameter int MON_BYTES = 13
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          arm,
  input  logic                          take,
  input  logic                          bound,
  input  logic [BYTE_W-1:0]             din,
  output logic                          busy,
  output logic                          shift_en,
  output logic [MON_BYTES*BYTE_W-1:0]   params
);
  localparam int PW  = MON_BYTES * BYTE_W;
  localparam int CW  = $clog2(MON_BYTES + 1);
  localparam logic [CW-1:0] LAST = CW'(MON_BYTES - 1);

  ld_state_e      state;
  logic [CW-1:0]  cnt;

  assign busy     = (state != LD_IDLE);
  assign shift_en = take && (state == LD_SHIFT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= LD_IDLE;
      cnt   <= '0;
    end else if (bound) begin
      state <= LD_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        LD_IDLE: if (arm) begin
          state <= LD_SHIFT;
          cnt   <= '0;
        end
        LD_SHIFT: if (shift_en) begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) state <= LD_DRAIN;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        params <= '0;
    else if (shift_en) params <= {params[PW-BYTE_W-1:0], din};
  end
endmodule

// File: rtl/mon_ctl_decoder.sv
module mon_ctl_decoder
  import mcd_pkg::*;
#(
  parameter int MON_BYTES = 13
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               byte_vld,
  input  logic [7:0]                         byte_data,
  input  logic                               xfer_bound,
  output logic [1:0]                         ref_sel,
  output logic                               ain3_is_ref,
  output logic                               ref_internal,
  output logic                               ref_pwr_on,
  output logic                               clk_ext,
  output logic                               single_ended,
  output logic                               bipolar,
  output logic [1:0]                         pos_ch,
  output logic [1:0]                         neg_ch,
  output logic                               neg_en,
  output logic                               int_clr,
  output logic [MON_BYTES*8-1:0]             mon_params
);
  setup_t setup_q;
  cfg_t   cfg_q;

  // named decode events, also watched by the checker
  logic accept, ld_busy, setup_hit, cfg_hit, rst_cmd, mon_arm, mon_hit;

  assign accept    = byte_vld && !xfer_bound;
  assign setup_hit = accept && !ld_busy &&  byte_data[KIND_BIT];
  assign cfg_hit   = accept && !ld_busy && !byte_data[KIND_BIT];
  assign rst_cmd   = setup_hit && !byte_data[CLRN_BIT];
  assign mon_arm   = setup_hit &&  byte_data[MON_BIT];

  mcd_setup_reg u_setup (
    .clk(clk), .rst_n(rst_n), .load(setup_hit), .din(byte_data), .q(setup_q)
  );

  mcd_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .load(cfg_hit), .clear(rst_cmd),
    .din(byte_data), .q(cfg_q)
  );

  mcd_mon_loader #(.MON_BYTES(MON_BYTES)) u_mon (
    .clk(clk), .rst_n(rst_n), .arm(mon_arm), .take(accept), .bound(xfer_bound),
    .din(byte_data), .busy(ld_busy), .shift_en(mon_hit), .params(mon_params)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) int_clr <= 1'b0;
    else        int_clr <= rst_cmd;
  end

  assign ref_sel      = setup_q.ref_sel;
  assign ain3_is_ref  = setup_q.ref_sel[0];
  assign ref_internal = setup_q.ref_sel[1];
  assign ref_pwr_on   = setup_q.pwr_on;
  assign clk_ext      = setup_q.clk_ext;
  assign single_ended = cfg_q.se;
  assign bipolar      = eff_bipolar(cfg_q, setup_q);
  assign pos_ch       = cfg_q.code;
  assign neg_ch       = partner_ch(cfg_q.code);
  assign neg_en       = !cfg_q.se;
endmodule

// File: rtl/mcd_checker.sv
module mcd_checker #(
  parameter int PW = 104
) (
  input logic          clk,
  input logic          rst_n,
  input logic          setup_hit,
  input logic          cfg_hit,
  input logic          rst_cmd,
  input logic          mon_hit,
  input logic          xfer_bound,
  input logic [1:0]    ref_sel,
  input logic          ref_pwr_on,
  input logic          clk_ext,
  input logic          single_ended,
  input logic          bipolar,
  input logic [1:0]    pos_ch,
  input logic [1:0]    neg_ch,
  input logic          int_clr,
  input logic [PW-1:0] mon_params
);
  AST_CLEAR_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    rst_cmd |=> (single_ended && pos_ch == 2'b00)); // R4
  AST_INT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_cmd |=> int_clr); // R4
  AST_INT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_cmd |=> !int_clr); // R4
  AST_SE_UNIPOLAR: assert property (@(posedge clk) disable iff (!rst_n)
    single_ended |-> !bipolar); // R5
  AST_DIFF_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    !single_ended |-> (neg_ch != pos_ch && neg_ch[1] == pos_ch[1])); // R6
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_hit && !rst_cmd) |=> $stable({single_ended, pos_ch})); // R3
  AST_SETUP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !setup_hit |=> $stable({ref_sel, ref_pwr_on, clk_ext})); // R2
  AST_MON_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_hit |=> $stable(mon_params)); // R9
  AST_BOUND_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_bound |=> ($stable(mon_params) && $stable({ref_sel, single_ended, pos_ch}))); // R10
  AST_EXCL_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({setup_hit, cfg_hit, mon_hit}) <= 1); // R8
endmodule

bind mon_ctl_decoder mcd_checker #(.PW(MON_BYTES*8)) i_chk (
  .clk(clk), .rst_n(rst_n), .setup_hit(setup_hit), .cfg_hit(cfg_hit),
  .rst_cmd(rst_cmd), .mon_hit(mon_hit), .xfer_bound(xfer_bound),
  .ref_sel(ref_sel), .ref_pwr_on(ref_pwr_on), .clk_ext(clk_ext),
  .single_ended(single_ended), .bipolar(bipolar), .pos_ch(pos_ch),
  .neg_ch(neg_ch), .int_clr(int_clr), .mon_params(mon_params)
);

// File: tb/test_mon_ctl_decoder.sv
module test_mon_ctl_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic byte_vld = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic xfer_bound = 1'b0;
  logic [1:0] ref_sel, pos_ch, neg_ch;
  logic ain3_is_ref, ref_internal, ref_pwr_on, clk_ext, single_ended, bipolar, neg_en, int_clr;
  logic [103:0] mon_params;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mon_ctl_decoder i_mon_ctl_decoder (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_data(byte_data),
    .xfer_bound(xfer_bound), .ref_sel(ref_sel), .ain3_is_ref(ain3_is_ref),
    .ref_internal(ref_internal), .ref_pwr_on(ref_pwr_on), .clk_ext(clk_ext),
    .single_ended(single_ended), .bipolar(bipolar), .pos_ch(pos_ch),
    .neg_ch(neg_ch), .neg_en(neg_en), .int_clr(int_clr), .mon_params(mon_params)
  );

  // behavioural reference model
  int m_ref, m_pwr, m_clk, m_bip, m_se, m_code, m_mode, m_cnt, m_int;
  byte unsigned m_q[$];

  function automatic logic [103:0] model_mon();
    logic [103:0] v = '0;
    foreach (m_q[i]) v = (v << 8) | 104'(m_q[i]);
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ref = 0; m_pwr = 0; m_clk = 0; m_bip = 0; m_se = 1; m_code = 0;
      m_mode = 0; m_cnt = 0; m_int = 0; m_q.delete();
    end else begin
      m_int = 0;
      if (xfer_bound) begin
        m_mode = 0; m_cnt = 0;
      end else if (byte_vld) begin
        if (m_mode == 0) begin
          if (byte_data[7]) begin
            m_ref = byte_data[6:5]; m_pwr = byte_data[4];
            m_clk = byte_data[3];   m_bip = byte_data[2];
            if (!byte_data[1]) begin m_se = 1; m_code = 0; m_int = 1; end
            if (byte_data[0]) begin m_mode = 1; m_cnt = 0; end
          end else begin
            m_se = byte_data[0]; m_code = byte_data[2:1];
          end
        end else if (m_mode == 1) begin
          m_q.push_back(byte_data);
          if (m_q.size() > 13) void'(m_q.pop_front());
          m_cnt++;
          if (m_cnt == 13) m_mode = 2;
        end
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [103:0] act, input logic [103:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison (outputs depend only on registers)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int exp_pos, exp_neg;
      exp_pos = m_code;
      exp_neg = m_code ^ 1;
      chk("R2", "ref_sel", 104'(ref_sel), 104'(m_ref));
      chk("R2", "pwr/clk", 104'({ref_pwr_on, clk_ext}), 104'({m_pwr[0], m_clk[0]}));
      chk("R7", "ain3/int", 104'({ain3_is_ref, ref_internal}), 104'({m_ref[0], m_ref[1]}));
      chk("R3", "single_ended", 104'(single_ended), 104'(m_se));
      chk("R5", "bipolar", 104'(bipolar), 104'((m_se == 0) && (m_bip == 1)));
      chk("R6", "pos_ch", 104'(pos_ch), 104'(exp_pos));
      chk("R6", "neg_en", 104'(neg_en), 104'(m_se == 0));
      if (!m_se) chk("R6", "neg_ch", 104'(neg_ch), 104'(exp_neg & 3));
      chk("R4", "int_clr", 104'(int_clr), 104'(m_int));
      chk("R8", "mon_params", mon_params, model_mon());
    end
  end

  // stimulus helpers, each called at a negedge
  task automatic put(input logic [7:0] b);
    byte_vld = 1'b1; byte_data = b; xfer_bound = 1'b0;
    @(negedge clk);
    byte_vld = 1'b0;
  endtask

  task automatic bound();
    xfer_bound = 1'b1; byte_vld = 1'b0;
    @(negedge clk);
    xfer_bound = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(posedge clk) cycles++;

  initial begin
    logic [103:0] exp_mon;
    logic [1:0] keep_ref;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "reset setup", 104'({ref_sel, ref_pwr_on, clk_ext, bipolar}), 104'(0));
    chk("R1", "reset cfg", 104'({single_ended, pos_ch, neg_en}), 104'({1'b1, 2'b00, 1'b0}));
    chk("R1", "reset mon/int", 104'({mon_params != 0, int_clr}), 104'(0));

    // R2 / R7: setup writes, reset bit kept at 1, monitor bit 0
    put(8'hB6); put(8'hCA); put(8'hFE); put(8'h82);
    put(8'hA6);  // bipolar request while single-ended
    chk("R5", "se overrides bipolar", 104'(bipolar), 104'(0));

    // R3 / R5 / R6: every differential code with bipolar requested
    for (int c = 0; c < 4; c++) begin
      put(8'(c << 1));
      chk("R6", "diff pos", 104'(pos_ch), 104'(c));
      chk("R6", "diff neg", 104'(neg_ch), 104'(c ^ 1));
      chk("R5", "diff bipolar", 104'(bipolar), 104'(1));
    end
    put(8'h7D);  // upper bits junk, single-ended, code 10
    chk("R3", "se code", 104'({single_ended, pos_ch}), 104'({1'b1, 2'b10}));
    put(8'h04);  // differential code 10

    // R4: reset bit 0 with other fields set
    put(8'hD4);
    chk("R4", "cfg cleared", 104'({single_ended, pos_ch}), 104'({1'b1, 2'b00}));
    chk("R4", "setup loaded", 104'({ref_sel, ref_pwr_on}), 104'({2'b10, 1'b1}));
    chk("R4", "int pulse", 104'(int_clr), 104'(1));
    @(negedge clk);
    chk("R4", "int pulse ends", 104'(int_clr), 104'(0));
    bound();

    // R8 / R9: full load plus extras
    put(8'h83);
    exp_mon = '0;
    for (int i = 0; i < 13; i++) begin
      put(8'h10 + 8'(i));
      exp_mon = (exp_mon << 8) | 104'(8'h10 + i);
    end
    keep_ref = ref_sel;
    put(8'h00); put(8'hFF);
    chk("R9", "extras ignored mon", mon_params, exp_mon);
    chk("R9", "extras ignored ctl", 104'({ref_sel, single_ended}), 104'({keep_ref, 1'b1}));
    chk("R8", "first byte on top", 104'(mon_params[103:96]), 104'(8'h10));
    bound();
    put(8'h03);
    chk("R9", "decode after bound", 104'({single_ended, pos_ch}), 104'({1'b1, 2'b01}));

    // R9: partial load cut by boundary
    put(8'hA3);
    for (int i = 0; i < 5; i++) put(8'hE0 + 8'(i));
    bound();
    chk("R9", "partial kept", 104'(mon_params[39:0]), 104'(40'hE0E1E2E3E4));
    put(8'h06);
    chk("R9", "normal after partial", 104'({single_ended, pos_ch}), 104'({1'b0, 2'b11}));

    // R10: byte coincident with boundary
    keep_ref = ref_sel;
    byte_vld = 1'b1; byte_data = 8'hFC; xfer_bound = 1'b1;
    @(negedge clk);
    byte_vld = 1'b0; xfer_bound = 1'b0;
    chk("R10", "coincident byte dropped", 104'({ref_sel, single_ended}), 104'({keep_ref, 1'b0}));
    chk("R10", "no int on dropped", 104'(int_clr), 104'(0));

    // mixed traffic
    for (int k = 0; k < 400; k++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r == 0) bound();
      else if (r == 1) @(negedge clk);
      else put(8'($urandom));
    end
    repeat (2) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule